// File: doc/BRIEF.md
# Register Alias Table with Broadcast Update

This block is the rename table of an out-of-order core. It holds one row for each architectural register. A row is either holding a committed-to-table value or waiting on a producer tag. A tag is the identifier of the reservation-station slot that will compute the register's newest value. For each accepted rename request, the table looks up the two source registers and hands each one on. A source comes out either as a ready value or as the tag to wait for. In the same cycle, the new producer's tag is recorded as the latest writer of the destination register.

The table also watches the result broadcast bus. A broadcast writes its value into a row only while that row is waiting and its stored tag equals the broadcast tag. A stale result, meaning one whose register has since been claimed by a younger writer, is dropped. Because of this rule, write-after-read and write-after-write hazards never stall the front end.

Each row is a two-state machine. The states are `ROW_READY`, which holds a value, and `ROW_PENDING`, which waits on a tag. There are three named transitions:
- CLAIM moves a row from READY to PENDING, or from PENDING to PENDING (re-claim), when the row is the destination of an accepted rename.
- FILL moves a row from PENDING to READY when a matching broadcast arrives and no claim is present.
- HOLD keeps the current state in every other case.

Renamed operands are registered and appear one cycle after the request.

Top module: `rat_core`

## Requirements
- R1: After reset every row is in READY with value 0, and `out_valid` and all operand outputs are 0.
- R2: A source whose row is READY is reported with ready=1, the row's value, and tag output 0.
- R3: A source whose row is PENDING, and which gets no matching broadcast that cycle, is reported with ready=0, value output 0, and the stored tag.
- R4: An accepted rename moves the destination row to PENDING and stores `ren_tag` as that row's tag.
- R5: A broadcast whose tag equals the tag of a PENDING row writes `bc_value` into the row and returns it to READY.
- R6: A broadcast is ignored by a PENDING row with a different tag and by every READY row, whatever tag the READY row last held.
- R7: A rename is accepted only when `ren_valid` and `rs_free` are both 1 (`ren_accept`). Otherwise the table is unchanged, `out_valid` is 0 in the next cycle, and all operand outputs keep their previous values.
- R8: If a source row is PENDING and a broadcast with its tag arrives in the cycle of the lookup, the source is reported ready with the broadcast value.
- R9: When a request reads and writes the same register, the sources see the mapping held before the destination update.
- R10: If an accepted rename and a matching broadcast hit the destination row in the same cycle, the rename wins: the row stays PENDING on the new tag.
- R11: `out_valid` and the operand outputs are registered. They reflect a request accepted at clock edge k right after edge k, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| rs_free | input | 1 | A reservation-station slot is available |
| ren_src_a | input | 4 | First source register index |
| ren_src_b | input | 4 | Second source register index |
| ren_dst | input | 4 | Destination register index |
| ren_tag | input | 3 | Tag allocated to the renamed instruction |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 3 | Tag of the broadcast result |
| bc_value | input | 32 | Broadcast result value |
| ren_accept | output | 1 | Request accepted this cycle |
| out_valid | output | 1 | Renamed operands valid |
| opa_ready | output | 1 | Source A is a value |
| opa_value | output | 32 | Source A value (0 when waiting) |
| opa_tag | output | 3 | Source A tag (0 when ready) |
| opb_ready | output | 1 | Source B is a value |
| opb_value | output | 32 | Source B value (0 when waiting) |
| opb_tag | output | 3 | Source B tag (0 when ready) |

## Verification
`ren_accept` is combinational and is due in the same cycle as the request. The renamed operands and `out_valid` are due one edge after the request. A row update from a claim or a fill first shows up in the operands of a request issued one cycle after the update. The bench drives each step on a falling edge. It compares the outputs on the next falling edge, half a cycle after the capturing rising edge, and only then drives the next step. As a result, every comparison sees exactly one capture, and the table state that capture was based on.

// File: rtl/rat_pkg.sv
package rat_pkg;

    // Row condition: holding a value, or waiting on a producer tag.
    typedef enum logic {
        ROW_READY   = 1'b0,
        ROW_PENDING = 1'b1
    } row_state_e;

    // Event selected for a row in a cycle.
    typedef enum logic [1:0] {
        EV_HOLD  = 2'd0,
        EV_CLAIM = 2'd1,
        EV_FILL  = 2'd2
    } row_event_e;

endpackage

// File: rtl/rat_row.sv
module rat_row
    import rat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output row_state_e        state_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] value_q
);

    row_state_e state_d;
    row_event_e ev;
    logic       bc_hit;

    assign bc_hit = bc_valid && (bc_tag == tag_q);

    // Event choice: a claim outranks a fill (younger writer wins).
    always_comb begin
        if (claim) begin
            ev = EV_CLAIM;
        end else if ((state_q == ROW_PENDING) && bc_hit) begin
            ev = EV_FILL;
        end else begin
            ev = EV_HOLD;
        end
    end

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ROW_READY:   state_d = (ev == EV_CLAIM) ? ROW_PENDING : ROW_READY;
            ROW_PENDING: state_d = (ev == EV_FILL)  ? ROW_READY   : ROW_PENDING;
            default:     state_d = ROW_READY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ROW_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Row contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            unique case (ev)
                EV_CLAIM: tag_q   <= claim_tag;
                EV_FILL:  value_q <= bc_value;
                default:  ;
            endcase
        end
    end

    // R4: a claim leaves the row waiting on the new tag.
    p_claim_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (state_q == ROW_PENDING) && (tag_q == $past(claim_tag)));

    // R5: a matching broadcast on a waiting row fills it.
    p_fill_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim && state_q == ROW_PENDING && bc_valid && bc_tag == tag_q)
        |=> (state_q == ROW_READY) && (value_q == $past(bc_value)));

    // R6: a ready row ignores every broadcast.
    p_ready_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim && state_q == ROW_READY)
        |=> (state_q == ROW_READY) && $stable(value_q));

    // R6: a waiting row ignores a broadcast with another tag.
    p_mismatch_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim && state_q == ROW_PENDING && !(bc_valid && bc_tag == tag_q))
        |=> (state_q == ROW_PENDING) && $stable(tag_q));

endmodule

// File: rtl/rat_dest_decode.sv
module rat_dest_decode #(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                accept,
    input  logic [IDX_W-1:0]    dst,
    output logic [NUM_REGS-1:0] claim
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_claim
        assign claim[g] = accept && (dst == IDX_W'(g));
    end

endmodule

// File: rtl/rat_src_port.sv
module rat_src_port #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 3,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]           sel,
    input  logic [NUM_REGS-1:0]        row_pending,
    input  logic [NUM_REGS*TAG_W-1:0]  row_tags,
    input  logic [NUM_REGS*DATA_W-1:0] row_values,
    input  logic                       bc_valid,
    input  logic [TAG_W-1:0]           bc_tag,
    input  logic [DATA_W-1:0]          bc_value,
    output logic                       ready,
    output logic [DATA_W-1:0]          value,
    output logic [TAG_W-1:0]           tag
);

    logic [TAG_W-1:0]  tag_sel;
    logic [DATA_W-1:0] val_sel;
    logic              pend_sel;

    always_comb begin
        tag_sel  = row_tags[int'(sel)*TAG_W +: TAG_W];
        val_sel  = row_values[int'(sel)*DATA_W +: DATA_W];
        pend_sel = row_pending[sel];
        if (!pend_sel) begin
            ready = 1'b1;
            value = val_sel;
            tag   = '0;
        end else if (bc_valid && (bc_tag == tag_sel)) begin
            // Same-cycle bypass of the broadcast result.
            ready = 1'b1;
            value = bc_value;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = tag_sel;
        end
    end

endmodule

// File: rtl/rat_core.sv
module rat_core
    import rat_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic              rs_free,
    input  logic [IDX_W-1:0]  ren_src_a,
    input  logic [IDX_W-1:0]  ren_src_b,
    input  logic [IDX_W-1:0]  ren_dst,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              ren_accept,
    output logic              out_valid,
    output logic              opa_ready,
    output logic [DATA_W-1:0] opa_value,
    output logic [TAG_W-1:0]  opa_tag,
    output logic              opb_ready,
    output logic [DATA_W-1:0] opb_value,
    output logic [TAG_W-1:0]  opb_tag
);

    logic [NUM_REGS-1:0]        claim;
    logic [NUM_REGS-1:0]        row_pending;
    logic [NUM_REGS*TAG_W-1:0]  row_tags;
    logic [NUM_REGS*DATA_W-1:0] row_values;
    row_state_e                 row_state [NUM_REGS];

    logic              a_ready, b_ready;
    logic [DATA_W-1:0] a_value, b_value;
    logic [TAG_W-1:0]  a_tag, b_tag;

    assign ren_accept = ren_valid && rs_free;

    rat_dest_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .accept (ren_accept),
        .dst    (ren_dst),
        .claim  (claim)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
        rat_row #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim[g]),
            .claim_tag (ren_tag),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .state_q   (row_state[g]),
            .tag_q     (row_tags[g*TAG_W +: TAG_W]),
            .value_q   (row_values[g*DATA_W +: DATA_W])
        );
        assign row_pending[g] = (row_state[g] == ROW_PENDING);
    end

    // Lookups see the table before this cycle's claim (old mapping).
    rat_src_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_a (
        .sel         (ren_src_a),
        .row_pending (row_pending),
        .row_tags    (row_tags),
        .row_values  (row_values),
        .bc_valid    (bc_valid),
        .bc_tag      (bc_tag),
        .bc_value    (bc_value),
        .ready       (a_ready),
        .value       (a_value),
        .tag         (a_tag)
    );

    rat_src_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_b (
        .sel         (ren_src_b),
        .row_pending (row_pending),
        .row_tags    (row_tags),
        .row_values  (row_values),
        .bc_valid    (bc_valid),
        .bc_tag      (bc_tag),
        .bc_value    (bc_value),
        .ready       (b_ready),
        .value       (b_value),
        .tag         (b_tag)
    );

    // Operand output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            opa_ready <= 1'b0;
            opa_value <= '0;
            opa_tag   <= '0;
            opb_ready <= 1'b0;
            opb_value <= '0;
            opb_tag   <= '0;
        end else begin
            out_valid <= ren_accept;
            if (ren_accept) begin
                opa_ready <= a_ready;
                opa_value <= a_value;
                opa_tag   <= a_tag;
                opb_ready <= b_ready;
                opb_value <= b_value;
                opb_tag   <= b_tag;
            end
        end
    end

    // R7: without acceptance, no new operands and outputs hold.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_accept |=> !out_valid && $stable(opa_value) && $stable(opb_value)
                        && $stable(opa_tag) && $stable(opb_tag)
                        && $stable(opa_ready) && $stable(opb_ready));

    // R2: a ready operand carries tag 0.
    p_ready_tag_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && opa_ready) |-> (opa_tag == '0));

    // R3: a waiting operand carries value 0.
    p_pending_value_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !opb_ready) |-> (opb_value == '0));

    // R8: a waiting source hit by a broadcast in the lookup cycle leaves ready.
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_accept && row_pending[ren_src_a] && bc_valid
         && bc_tag == row_tags[int'(ren_src_a)*TAG_W +: TAG_W])
        |=> opa_ready && (opa_value == $past(bc_value)));

    // R10: a claim outranks a same-cycle matching fill of the destination.
    p_claim_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ren_accept |=> row_pending[$past(ren_dst)]);

endmodule

// File: tb/rat_core_test.sv
`timescale 1ns/1ps
module rat_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ren_valid = 1'b0, rs_free = 1'b0;
    logic [3:0]  ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic [2:0]  ren_tag = '0;
    logic        bc_valid = 1'b0;
    logic [2:0]  bc_tag = '0;
    logic [31:0] bc_value = '0;
    logic        ren_accept, out_valid, opa_ready, opb_ready;
    logic [31:0] opa_value, opb_value;
    logic [2:0]  opa_tag, opb_tag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rat_core uut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .rs_free(rs_free),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_tag(ren_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .ren_accept(ren_accept), .out_valid(out_valid),
        .opa_ready(opa_ready), .opa_value(opa_value), .opa_tag(opa_tag),
        .opb_ready(opb_ready), .opb_value(opb_value), .opb_tag(opb_tag)
    );

    typedef struct packed {
        logic        rv;
        logic        free;
        logic [3:0]  sa;
        logic [3:0]  sb;
        logic [3:0]  dst;
        logic [2:0]  tag;
        logic        bv;
        logic [2:0]  btag;
        logic [31:0] bval;
        logic        e_valid;
        logic        ea_r;
        logic [31:0] ea_v;
        logic [2:0]  ea_t;
        logic        eb_r;
        logic [31:0] eb_v;
        logic [2:0]  eb_t;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        // R2: both sources ready at reset value; r3 claimed with tag 1
        '{1,1, 1, 2, 3, 1, 0,0,32'h0,   1, 1,32'h0,0,   1,32'h0,0,  2},
        // R3 / R4: r3 now waiting on tag 1; r5 claimed with tag 2
        '{1,1, 3, 4, 5, 2, 0,0,32'h0,   1, 0,32'h0,1,   1,32'h0,0,  3},
        // R8: broadcast tag 1 bypasses into source r3; r5 still waiting
        '{1,1, 3, 5, 6, 3, 1,1,32'h11,  1, 1,32'h11,0,  0,32'h0,2,  8},
        // R5 / R6: r3 now filled; broadcast tag 5 matches nothing
        '{1,1, 3, 6, 7, 4, 1,5,32'h99,  1, 1,32'h11,0,  0,32'h0,3,  6},
        // R7: no free slot; outputs hold, r5 untouched
        '{1,0, 5, 5, 5, 6, 0,0,32'h0,   0, 1,32'h11,0,  0,32'h0,3,  7},
        // R9: read and write r5 in one request, old tag 2 seen
        '{1,1, 5, 5, 5, 6, 0,0,32'h0,   1, 0,32'h0,2,   0,32'h0,2,  9},
        // R6: stale broadcast tag 2 ignored by r5 now on tag 6
        '{1,1, 5, 3, 8, 0, 1,2,32'h22,  1, 0,32'h0,6,   1,32'h11,0, 6},
        // R8: broadcast tag 6 bypasses into r5
        '{1,1, 5, 8, 9, 1, 1,6,32'h66,  1, 1,32'h66,0,  0,32'h0,0,  8},
        // R10: r8 reclaimed with tag 2 while tag 0 broadcast lands
        '{1,1, 8, 9, 8, 2, 1,0,32'h80,  1, 1,32'h80,0,  0,32'h0,1, 10},
        // R10: r8 still waiting, on tag 2
        '{1,1, 8, 5,10, 5, 0,0,32'h0,   1, 0,32'h0,2,   1,32'h66,0, 10},
        // R7: no request; broadcast tag 2 fills r8, outputs hold
        '{0,1, 0, 0, 0, 0, 1,2,32'h82,  0, 0,32'h0,2,   1,32'h66,0,  7},
        // R5: r8 filled by that broadcast
        '{1,1, 8, 0,15, 7, 0,0,32'h0,   1, 1,32'h82,0,  1,32'h0,0,  5},
        // R6: tag 1 broadcast fills r9 and leaves ready r3 (old tag 1) alone
        '{1,1, 3, 9,15, 7, 1,1,32'hAA,  1, 1,32'h11,0,  1,32'hAA,0,  6},
        // R5 / R6: r9 holds the fill, r3 unchanged
        '{1,1, 9, 3,15, 7, 0,0,32'h0,   1, 1,32'hAA,0,  1,32'h11,0,  5},
        // R8: tag 4 bypass into r7; r6 still waits on tag 3
        '{1,1, 7, 6,15, 7, 1,4,32'h44,  1, 1,32'h44,0,  0,32'h0,3,  8}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ren_valid = 1'b0; rs_free = 1'b1; bc_valid = 1'b0;
        ren_src_a = '0; ren_src_b = '0; ren_dst = '0; ren_tag = '0;
        bc_tag = '0; bc_value = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        string tagname;
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs at reset
        check("R1", "out_valid", 32'(out_valid), 0);
        check("R1", "opa_value", opa_value, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after release", 32'(out_valid), 0);

        // Vector walk: drive on a falling edge, compare on the next one (R11).
        for (int i = 0; i < NVEC; i++) begin
            ren_valid = VECS[i].rv;   rs_free  = VECS[i].free;
            ren_src_a = VECS[i].sa;   ren_src_b = VECS[i].sb;
            ren_dst   = VECS[i].dst;  ren_tag  = VECS[i].tag;
            bc_valid  = VECS[i].bv;   bc_tag   = VECS[i].btag;
            bc_value  = VECS[i].bval;
            #1;
            tagname = $sformatf("R%0d", VECS[i].req);
            check("R7", $sformatf("ren_accept v%0d", i), 32'(ren_accept),
                  32'(VECS[i].rv & VECS[i].free));
            @(negedge clk);
            check("R11", $sformatf("out_valid v%0d", i), 32'(out_valid), 32'(VECS[i].e_valid));
            check(tagname, $sformatf("opa_ready v%0d", i), 32'(opa_ready), 32'(VECS[i].ea_r));
            check(tagname, $sformatf("opa_value v%0d", i), opa_value, VECS[i].ea_v);
            check(tagname, $sformatf("opa_tag v%0d", i), 32'(opa_tag), 32'(VECS[i].ea_t));
            check(tagname, $sformatf("opb_ready v%0d", i), 32'(opb_ready), 32'(VECS[i].eb_r));
            check(tagname, $sformatf("opb_value v%0d", i), opb_value, VECS[i].eb_v);
            check(tagname, $sformatf("opb_tag v%0d", i), 32'(opb_tag), 32'(VECS[i].eb_t));
            idle();
        end

        // R11: one cycle after the last request out_valid drops.
        @(negedge clk);
        check("R11", "out_valid single pulse", 32'(out_valid), 0);

        // R1: reset from a dirty table, then read back every row.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "out_valid in reset", 32'(out_valid), 0);
        check("R1", "opb_tag in reset", 32'(opb_tag), 0);
        rst_n = 1'b1;
        for (int p = 7; p >= 0; p--) begin
            ren_valid = 1'b1; rs_free = 1'b1;
            ren_src_a = 4'(2*p); ren_src_b = 4'(2*p+1);
            ren_dst = 4'(2*p); ren_tag = 3'd0;
            @(negedge clk);
            check("R1", $sformatf("row %0d ready", 2*p),   32'(opa_ready), 1);
            check("R1", $sformatf("row %0d value", 2*p),   opa_value, 0);
            check("R1", $sformatf("row %0d ready", 2*p+1), 32'(opb_ready), 1);
            check("R1", $sformatf("row %0d value", 2*p+1), opb_value, 0);
            idle();
        end

        done = 1'b1;
        finish_run();
    end

endmodule